// File: doc/BRIEF.md
# Width-Scaled Transmit/Receive FIFO Pair

This block holds the transmit and receive word queues of a serial port controller. Each queue has 32 words of storage. The number of words each queue may actually hold, its usable depth, is picked at run time from the configured frame width and a large-queue enable. Wider frames get fewer usable entries, while the storage itself never changes.

Each queue reports four occupancy flags: full, one-before-full, empty and one-before-empty. A neighbouring register block decodes them from a 12-bit status word whose bit positions are fixed. A push into a full transmit queue is dropped silently. A word that arrives at a full receive queue is lost, and that loss raises an overflow indication in two places. The first is a status bit that any receive pop clears. The second is a raw interrupt bit that only an explicit clear strobe removes. When the usable depth changes, both queues are flushed, so occupancy can never exceed the new limit.

Top module: `spiFifoPair`

## Requirements
- R1: After reset both queues are empty, both overflow indications are clear, `statusWord` reads 0x440 and `curDepth` reads 4, given a frame width of 8 with the large-queue enable low.
- R2: With `bigFifoEn` high, the usable depth is 32 for frame widths 0..8, 16 for widths 9..16, 8 for widths 17..32 and 4 for widths 33..63.
- R3: With `bigFifoEn` low, the usable depth is 4 for every frame width.
- R4: A transmit push made while the transmit queue holds depth words changes nothing: neither the flags nor the order or content of the words popped later.
- R5: The status word positions are fixed as follows. Receive side: full bit 4, one-before-full bit 5, empty bit 6, one-before-empty bit 7. Transmit side: full bit 8, one-before-full bit 9, empty bit 10, one-before-empty bit 11. Full means occupancy equals depth, and one-before-full means occupancy equals depth-1.
- R6: Empty means occupancy 0 and one-before-empty means occupancy exactly 1. Words leave each queue in the order they entered, and the head word is shown on the pop data output before it is popped.
- R7: A receive push while the receive queue holds depth words is dropped. In the following cycle it sets status bit 2 and `rawOvf`.
- R8: Any receive pop with no overflow in the same cycle clears status bit 2. `rawOvf` is cleared only by `ovfClr`. A new overflow in the same cycle wins over either clear.
- R9: The cycle after the computed depth differs from `curDepth`, `curDepth` takes the new value and both queues are empty. Pushes and pops in the cycle where the difference is seen are ignored.
- R10: A pop from an empty queue has no effect. A push and a pop in the same cycle on a queue that is neither empty nor full leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameWidth | input | 6 | Configured frame width in bits |
| bigFifoEn | input | 1 | Enables depths above 4 |
| txPush | input | 1 | Write a word into the transmit queue |
| txPushData | input | 32 | Word to write into the transmit queue |
| txPop | input | 1 | Remove the transmit head word |
| txPopData | output | 32 | Current transmit head word |
| rxPush | input | 1 | Received word arrives |
| rxPushData | input | 32 | Received word |
| rxPop | input | 1 | Remove the receive head word |
| rxPopData | output | 32 | Current receive head word |
| ovfClr | input | 1 | Clears the raw overflow indication |
| statusWord | output | 12 | Occupancy flags and overflow status bit |
| rawOvf | output | 1 | Sticky raw receive-overflow indication |
| curDepth | output | 6 | Usable depth now in force |

## Verification
A wrong occupancy count shows up in the flag bits of `statusWord` one cycle after the push or pop that caused it. If a full check is off by one, an extra word is accepted, or a dropped receive word fails to raise bit 2. Pointer errors do not show up in the flags. They show up only when a word leaves, as a mismatch between the head word and the order the words went in. For that reason every pop is compared against a queue of expected words. A flush missed on a depth change leaves stale words behind, and they appear in the flags one cycle after `curDepth` moves.

// File: rtl/spiFifoPkg.sv
package spiFifoPkg;
  localparam int STORE_WORDS = 32;
  localparam int PTR_W       = $clog2(STORE_WORDS);
  localparam int CNT_W       = PTR_W + 1;
  localparam int WIDTH_W     = 6;
  localparam int STAT_W      = 12;

  // write enable plus both storage indices for one queue
  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic [PTR_W-1:0] rdIdx;
  } fifoStrobe_t;

  // usable depth from frame width and large-queue enable
  function automatic logic [CNT_W-1:0] depthFor(input logic [WIDTH_W-1:0] w,
                                                input logic big);
    if (!big)                         return CNT_W'(4);
    else if (w <= WIDTH_W'(8))        return CNT_W'(32);
    else if (w <= WIDTH_W'(16))       return CNT_W'(16);
    else if (w <= WIDTH_W'(32))       return CNT_W'(8);
    else                              return CNT_W'(4);
  endfunction
endpackage

// File: rtl/spiFifoCtrl.sv
module spiFifoCtrl
  import spiFifoPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic               bigFifoEn,
  input  logic [1:0]         push,
  input  logic [1:0]         pop,
  input  logic               ovfClr,
  output fifoStrobe_t        strobe [2],
  output logic [STAT_W-1:0]  statusWord,
  output logic               rawOvf,
  output logic [CNT_W-1:0]   curDepth
);
  localparam int TX = 0;
  localparam int RX = 1;

  logic [CNT_W-1:0] depthReg;
  logic [CNT_W-1:0] depthNow;
  logic             reconfig;
  logic [PTR_W-1:0] idxMask;
  logic [1:0]       fullV, fullNextV, emptyV, emptyNextV;
  logic             ovfSts;
  logic             rxOvfHit;

  assign depthNow = depthFor(frameWidth, bigFifoEn);
  assign reconfig = (depthNow != depthReg);
  assign idxMask  = PTR_W'(depthReg - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) depthReg <= CNT_W'(4);
    else       depthReg <= depthNow;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] wp, rp;
    logic             accPush, accPop;

    assign accPush = push[ch] && !reconfig && (cnt < depthReg);
    assign accPop  = pop[ch]  && !reconfig && (cnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN || reconfig) begin
        cnt <= '0;
        wp  <= '0;
        rp  <= '0;
      end else begin
        if (accPush) wp <= wp + PTR_W'(1);
        if (accPop)  rp <= rp + PTR_W'(1);
        case ({accPush, accPop})
          2'b10:   cnt <= cnt + CNT_W'(1);
          2'b01:   cnt <= cnt - CNT_W'(1);
          default: cnt <= cnt;
        endcase
      end
    end

    assign strobe[ch].wrEn  = accPush;
    assign strobe[ch].wrIdx = wp & idxMask;
    assign strobe[ch].rdIdx = rp & idxMask;

    assign fullV[ch]      = (cnt == depthReg);
    assign fullNextV[ch]  = (cnt == depthReg - CNT_W'(1));
    assign emptyV[ch]     = (cnt == '0);
    assign emptyNextV[ch] = (cnt == CNT_W'(1));
  end

  assign rxOvfHit = push[RX] && !reconfig && fullV[RX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfSts <= 1'b0;
      rawOvf <= 1'b0;
    end else begin
      if (rxOvfHit)                 ovfSts <= 1'b1;
      else if (pop[RX] && !reconfig) ovfSts <= 1'b0;
      if (rxOvfHit)                 rawOvf <= 1'b1;
      else if (ovfClr)              rawOvf <= 1'b0;
    end
  end

  always_comb begin
    statusWord     = '0;
    statusWord[2]  = ovfSts;
    statusWord[4]  = fullV[RX];
    statusWord[5]  = fullNextV[RX];
    statusWord[6]  = emptyV[RX];
    statusWord[7]  = emptyNextV[RX];
    statusWord[8]  = fullV[TX];
    statusWord[9]  = fullNextV[TX];
    statusWord[10] = emptyV[TX];
    statusWord[11] = emptyNextV[TX];
  end

  assign curDepth = depthReg;
endmodule

// File: rtl/spiFifoStore.sv
module spiFifoStore
  import spiFifoPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [STORE_WORDS];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[strobe.wrIdx] <= wrData;
  end

  assign rdData = mem[strobe.rdIdx];
endmodule

// File: rtl/spiFifoPair.sv
module spiFifoPair
  import spiFifoPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic               bigFifoEn,
  input  logic               txPush,
  input  logic [DATA_W-1:0]  txPushData,
  input  logic               txPop,
  output logic [DATA_W-1:0]  txPopData,
  input  logic               rxPush,
  input  logic [DATA_W-1:0]  rxPushData,
  input  logic               rxPop,
  output logic [DATA_W-1:0]  rxPopData,
  input  logic               ovfClr,
  output logic [STAT_W-1:0]  statusWord,
  output logic               rawOvf,
  output logic [CNT_W-1:0]   curDepth
);
  fifoStrobe_t       strobe [2];
  logic [DATA_W-1:0] inData  [2];
  logic [DATA_W-1:0] outData [2];

  assign inData[0] = txPushData;
  assign inData[1] = rxPushData;
  assign txPopData = outData[0];
  assign rxPopData = outData[1];

  spiFifoCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameWidth (frameWidth),
    .bigFifoEn  (bigFifoEn),
    .push       ({rxPush, txPush}),
    .pop        ({rxPop, txPop}),
    .ovfClr     (ovfClr),
    .strobe     (strobe),
    .statusWord (statusWord),
    .rawOvf     (rawOvf),
    .curDepth   (curDepth)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_store
    spiFifoStore #(.DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .strobe (strobe[ch]),
      .wrData (inData[ch]),
      .rdData (outData[ch])
    );
  end
endmodule

// File: rtl/spiFifoPairChk.sv
module spiFifoPairChk
  import spiFifoPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [WIDTH_W-1:0] frameWidth,
  input logic               bigFifoEn,
  input logic               txPush,
  input logic               txPop,
  input logic               rxPush,
  input logic               rxPop,
  input logic               ovfClr,
  input logic [STAT_W-1:0]  statusWord,
  input logic               rawOvf,
  input logic [CNT_W-1:0]   curDepth
);
  logic cfgSteady;
  assign cfgSteady = (depthFor(frameWidth, bigFifoEn) == curDepth);

  // R2
  depth_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(curDepth) && curDepth >= CNT_W'(4));

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[8] && statusWord[10]) && !(statusWord[4] && statusWord[6]));

  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[8] && txPush && !txPop && cfgSteady) |=> statusWord[8]);

  // R7
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[4] && rxPush && cfgSteady) |=> (statusWord[2] && rawOvf));

  // R8
  ovf_pop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[2] && rxPop && !rxPush && cfgSteady) |=> !statusWord[2]);

  // R8
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawOvf && !ovfClr) |=> rawOvf);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curDepth) |-> (statusWord[6] && statusWord[10]));
endmodule

bind spiFifoPair spiFifoPairChk u_chk (.*);

// File: tb/spiFifoPair_bench.sv
`timescale 1ns/1ps
module spiFifoPair_bench;
  import spiFifoPkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rstN;
  logic [WIDTH_W-1:0] frameWidth;
  logic               bigFifoEn;
  logic               txPush, txPop, rxPush, rxPop, ovfClr;
  logic [31:0]        txPushData, rxPushData, txPopData, rxPopData;
  logic [STAT_W-1:0]  statusWord;
  logic               rawOvf;
  logic [CNT_W-1:0]   curDepth;

  spiFifoPair u_spiFifoPair (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];
  int  mDepth = 4;
  bit  mOvf = 0;
  bit  mRaw = 0;

  function automatic int refDepth(int w, bit big);
    if (!big) return 4;
    if (w <= 8) return 32;
    if (w <= 16) return 16;
    if (w <= 32) return 8;
    return 4;
  endfunction

  function automatic logic [11:0] expStatus();
    logic [11:0] s = '0;
    s[2]  = mOvf;
    s[4]  = (rxQ.size() == mDepth);
    s[5]  = (rxQ.size() == mDepth - 1);
    s[6]  = (rxQ.size() == 0);
    s[7]  = (rxQ.size() == 1);
    s[8]  = (txQ.size() == mDepth);
    s[9]  = (txQ.size() == mDepth - 1);
    s[10] = (txQ.size() == 0);
    s[11] = (txQ.size() == 1);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkStatus(input string req);
    check(statusWord == expStatus(), req, 32'(statusWord), 32'(expStatus()));
    check(rawOvf == mRaw, {req, " rawOvf"}, 32'(rawOvf), 32'(mRaw));
  endtask

  task automatic setCfg(input int w, input bit big);
    frameWidth = WIDTH_W'(w);
    bigFifoEn  = big;
    tick();
    if (refDepth(w, big) != mDepth) begin
      mDepth = refDepth(w, big);
      txQ.delete();
      rxQ.delete();
    end
  endtask

  // driver: stimulus and expected-queue update in one step
  task automatic pushTx(input logic [31:0] v);
    txPush = 1'b1; txPushData = v;
    tick();
    txPush = 1'b0;
    if (txQ.size() < mDepth) txQ.push_back(v);
  endtask

  task automatic pushRx(input logic [31:0] v);
    rxPush = 1'b1; rxPushData = v;
    tick();
    rxPush = 1'b0;
    if (rxQ.size() < mDepth) rxQ.push_back(v);
    else begin mOvf = 1; mRaw = 1; end
  endtask

  // monitor side: head compared before removal
  task automatic popTx(input string req);
    if (txQ.size() != 0) check(txPopData == txQ[0], req, txPopData, txQ[0]);
    txPop = 1'b1;
    tick();
    txPop = 1'b0;
    if (txQ.size() != 0) void'(txQ.pop_front());
  endtask

  task automatic popRx(input string req);
    if (rxQ.size() != 0) check(rxPopData == rxQ[0], req, rxPopData, rxQ[0]);
    rxPop = 1'b1;
    tick();
    rxPop = 1'b0;
    mOvf = 0;
    if (rxQ.size() != 0) void'(rxQ.pop_front());
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameWidth = 6'd8; bigFifoEn = 1'b0;
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0; ovfClr = 0;
    txPushData = '0; rxPushData = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check(statusWord == 12'h440, "R1 status", 32'(statusWord), 32'h440);
    check(curDepth == 4, "R1 depth", 32'(curDepth), 4);
    check(rawOvf == 0, "R1 rawOvf", 32'(rawOvf), 0);

    // R2 / R3 depth table
    begin
      int ws[7] = '{8, 0, 9, 16, 17, 32, 33};
      foreach (ws[i]) begin
        setCfg(ws[i], 1);
        check(curDepth == refDepth(ws[i], 1), "R2 depth", 32'(curDepth), refDepth(ws[i], 1));
      end
      setCfg(63, 1);
      check(curDepth == 4, "R2 depth w63", 32'(curDepth), 4);
      setCfg(8, 0);
      check(curDepth == 4, "R3 depth small", 32'(curDepth), 4);
      setCfg(40, 0);
      check(curDepth == 4, "R3 depth small wide", 32'(curDepth), 4);
    end

    // R5 R6 fill TX at depth 4, R4 drop on full
    checkStatus("R6 empty");
    pushTx(32'hA1); checkStatus("R6 emptyNext");
    pushTx(32'hA2); pushTx(32'hA3); checkStatus("R5 fullNext");
    pushTx(32'hA4); checkStatus("R5 full");
    pushTx(32'hDEAD); checkStatus("R4 drop flags");
    for (int i = 0; i < 4; i++) popTx("R4 R6 order");
    checkStatus("R6 drained");

    // R10 pop on empty, simultaneous push+pop
    popTx("R10 empty pop"); checkStatus("R10 empty pop");
    pushTx(32'h11); pushTx(32'h22);
    check(txPopData == 32'h11, "R10 head", txPopData, 32'h11);
    txPush = 1; txPushData = 32'h33; txPop = 1;
    tick();
    txPush = 0; txPop = 0;
    void'(txQ.pop_front()); txQ.push_back(32'h33);
    checkStatus("R10 push+pop");
    popTx("R10 order"); popTx("R10 order"); checkStatus("R10 drained");

    // R7 R8 receive overflow
    for (int i = 0; i < 4; i++) pushRx(32'hB0 + 32'(i));
    checkStatus("R5 rx full");
    pushRx(32'hBAD); checkStatus("R7 overflow");
    popRx("R7 order kept"); checkStatus("R8 pop clears status");
    ovfClr = 1; tick(); ovfClr = 0; mRaw = 0;
    checkStatus("R8 raw cleared");
    for (int i = 0; i < 3; i++) popRx("R7 order kept");
    checkStatus("R8 rx drained");

    // R8 overflow wins over pop in same cycle
    for (int i = 0; i < 4; i++) pushRx(32'hC0 + 32'(i));
    rxPush = 1; rxPushData = 32'hEE; rxPop = 1;
    tick();
    rxPush = 0; rxPop = 0;
    void'(rxQ.pop_front()); mOvf = 1; mRaw = 1;
    checkStatus("R8 set wins");

    // R9 flush on depth change, with big depth fill
    pushTx(32'h77);
    setCfg(8, 1);
    check(curDepth == 32, "R9 new depth", 32'(curDepth), 32);
    checkStatus("R9 flushed");
    for (int i = 0; i < 31; i++) pushTx(32'h1000 + 32'(i));
    checkStatus("R5 fullNext 32");
    pushTx(32'h2000); checkStatus("R5 full 32");
    pushTx(32'h3000); checkStatus("R4 drop 32");
    for (int i = 0; i < 32; i++) popTx("R6 order 32");
    checkStatus("R6 drained 32");

    // R9 push ignored in reconfig cycle
    frameWidth = 6'd20; txPush = 1; txPushData = 32'h55;
    tick();
    txPush = 0; mDepth = 8; txQ.delete(); rxQ.delete();
    check(curDepth == 8, "R9 depth 8", 32'(curDepth), 8);
    checkStatus("R9 push ignored");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule